// File: doc/BRIEF.md
# Dual Parallel I/O Adapter with Steered Direction Access

This block gives a bus master two independent 8-bit parallel ports inside a window of four consecutive byte addresses. Each port holds three registers: an output latch, a direction mask and a control byte. Only two of the port's addresses are visible to the bus, so the I/O address is shared between the output latch and the direction mask. The control byte selects which of the two that address reaches.

Software clears the selector bit in the control byte and writes the direction mask. It then sets the selector and uses the shared address for ordinary data transfers. A pin is driven only where its direction bit is set. A data read returns the latch on output bits and the synchronised pin level on input bits. The other control bits are kept as plain storage and read back unchanged.

Top module: `pio_dual_port`

## Requirements
- R1: After reset every register is 0. All pins are inputs (`pin_oe_o` = 0, `pin_o` = 0), and every offset reads 0.
- R2: Address bit 1 selects the port (offsets 0 and 1 belong to port 0, offsets 2 and 3 to port 1). Address bit 0 selects the control register when it is 1 and the shared I/O address when it is 0. A write reaches exactly one register of one port.
- R3: At the I/O offset, control bit 2 = 0 selects the direction mask for reads and writes. Control bit 2 = 1 selects the output latch, and writes in that state leave the direction mask unchanged.
- R4: For each bit, direction 1 drives `pin_oe_o` = 1 and `pin_o` = latch bit. Direction 0 drives `pin_oe_o` = 0 and `pin_o` = 0.
- R5: A read of the output latch returns the latch value on bits whose direction is 1 and the synchronised pin value on bits whose direction is 0.
- R6: A write to the output latch stores all 8 bits, including bits whose direction is currently 0. The stored value appears on the pins when those bits later become outputs.
- R7: Input pins pass through two flops. A pin change that arrives before a rising edge first shows in a read after the second rising edge.
- R8: A cycle with `sel_i` = 0, or with `wr_i` = 0, changes no register. `rdata_o` is 0 while `sel_i` = 0.
- R9: A control register stores all 8 written bits and reads them back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Offset within the four-address window |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| pin_i | input | 16 | Pin levels; port p on bits [8p+7:8p] |
| pin_o | output | 16 | Pin drive values |
| pin_oe_o | output | 16 | Pin drive enables |

## Verification
A corrupted direction mask shows on `pin_oe_o` in the cycle after the faulty write. Reading the I/O offset with the selector clear also exposes it. A corrupted output latch shows on `pin_o` only for bits that are outputs. The bench therefore turns the latched bits into outputs later and checks them there. A wrong selector bit sends data writes into the direction mask, and the enable pins change at once. A synchroniser that is too short or too long shows as a read value arriving one edge early or one edge late. The bench samples both edges around the expected arrival to catch either case.

// File: rtl/pio_pkg.sv
package pio_pkg;
  parameter int unsigned PIO_W = 8;
  localparam int unsigned SEL_BIT = 2;

  typedef enum logic [1:0] {
    TGT_DIR  = 2'd0,
    TGT_DATA = 2'd1,
    TGT_CTRL = 2'd2
  } pio_tgt_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int unsigned W = PIO_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         io_we_i,
  input  logic         ctrl_we_i,
  input  logic         is_ctrl_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o
);
  logic [W-1:0] ddr_q, out_q, ctrl_q, pin_s;
  logic         data_sel;
  pio_tgt_e     tgt;

  pio_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  assign data_sel = ctrl_q[SEL_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ddr_q  <= '0;
      out_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= wdata_i;
      if (io_we_i) begin
        if (data_sel) out_q <= wdata_i;
        else          ddr_q <= wdata_i;
      end
    end
  end

  always_comb begin
    if (is_ctrl_i)     tgt = TGT_CTRL;
    else if (data_sel) tgt = TGT_DATA;
    else               tgt = TGT_DIR;
  end

  always_comb begin
    unique case (tgt)
      TGT_CTRL: rdata_o = ctrl_q;
      TGT_DATA: rdata_o = (out_q & ddr_q) | (pin_s & ~ddr_q);
      default:  rdata_o = ddr_q;
    endcase
  end

  assign pin_oe_o = ddr_q;
  assign pin_o    = out_q & ddr_q;

  p_dir_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_we_i && !data_sel |=> pin_oe_o == $past(wdata_i));

  p_dir_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_we_i && data_sel && !ctrl_we_i |=> $stable(pin_oe_o));

  p_latch_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_we_i && data_sel |=> ((pin_o ^ $past(wdata_i)) & pin_oe_o) == '0);

  p_ctrl_store_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> ctrl_q == $past(wdata_i));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_we_i && !ctrl_we_i |=> $stable(ddr_q) && $stable(out_q) && $stable(ctrl_q));
endmodule

// File: rtl/pio_dual_port.sv
module pio_dual_port
  import pio_pkg::*;
#(
  parameter int unsigned W  = PIO_W,
  parameter int unsigned NP = 2,
  localparam int unsigned PIDX_W = (NP > 1) ? $clog2(NP) : 1,
  localparam int unsigned ADDR_W = PIDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [NP*W-1:0]   pin_i,
  output logic [NP*W-1:0]   pin_o,
  output logic [NP*W-1:0]   pin_oe_o
);
  logic [PIDX_W-1:0] pidx;
  logic              is_ctrl;
  logic [NP-1:0]     io_we, ctrl_we;
  logic [W-1:0]      port_rd [NP];

  assign pidx    = addr_i[ADDR_W-1:1];
  assign is_ctrl = addr_i[0];

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic hit;
    assign hit        = sel_i && wr_i && (pidx == PIDX_W'(p));
    assign io_we[p]   = hit && !is_ctrl;
    assign ctrl_we[p] = hit && is_ctrl;

    pio_port #(.W(W)) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .io_we_i  (io_we[p]),
      .ctrl_we_i(ctrl_we[p]),
      .is_ctrl_i(is_ctrl),
      .wdata_i  (wdata_i),
      .pin_i    (pin_i[p*W +: W]),
      .rdata_o  (port_rd[p]),
      .pin_o    (pin_o[p*W +: W]),
      .pin_oe_o (pin_oe_o[p*W +: W])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NP; p++)
      if (sel_i && pidx == PIDX_W'(p)) rdata_o = port_rd[p];
  end

  p_single_target_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({io_we, ctrl_we}));

  p_no_write_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_i) |-> ({io_we, ctrl_we} == '0));
endmodule

// File: tb/tb_pio_dual_port.sv
module tb_pio_dual_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0, wr_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [15:0] pin_i = '0, pin_o, pin_oe_o;
  int          errors = 0, checks = 0;

  pio_dual_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    sel_i = 1'b1; wr_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    sel_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 pin_oe", pin_oe_o, 16'h0);
    check("R1 pin_o", pin_o, 16'h0);
    for (int a = 0; a < 4; a++) begin
      bus_rd(2'(a), d);
      check("R1 read", {8'h0, d}, 16'h0);
    end
  endtask

  task automatic t_direction;
    logic [7:0] d;
    bus_wr(2'd0, 8'hF0);
    bus_rd(2'd0, d);
    check("R3 dir readback", {8'h0, d}, 16'h00F0);
    check("R4 oe", pin_oe_o, 16'h00F0);
    bus_wr(2'd1, 8'h04);
    bus_wr(2'd0, 8'hA5);
    check("R3 dir held", pin_oe_o, 16'h00F0);
    check("R4 drive masked", pin_o, 16'h00A0);
  endtask

  task automatic t_merge_sync;
    logic [7:0] d;
    @(negedge clk_i); pin_i[7:0] = 8'h3C;
    repeat (2) @(negedge clk_i);
    bus_rd(2'd0, d);
    check("R5 merged read", {8'h0, d}, 16'h00AC);
    @(negedge clk_i); pin_i[7:0] = 8'hC3;
    @(negedge clk_i);
    bus_rd(2'd0, d);
    check("R7 after one edge", {8'h0, d}, 16'h00AC);
    @(negedge clk_i);
    bus_rd(2'd0, d);
    check("R7 after two edges", {8'h0, d}, 16'h00A3);
  endtask

  task automatic t_hidden_latch;
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'hFF);
    check("R6 latch on new outputs", pin_o, 16'h00A5);
  endtask

  task automatic t_isolation;
    logic [7:0] d;
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b1; addr_i = 2'd3; wdata_i = 8'hFF;
    @(negedge clk_i);
    wr_i = 1'b0;
    bus_rd(2'd3, d);
    check("R8 unselected write", {8'h0, d}, 16'h0);
    #1 check("R8 rdata idle", {8'h0, rdata_o}, 16'h0);
    bus_rd(2'd2, d);
    check("R2 port1 untouched", {8'h0, d}, 16'h0);
    check("R2 port1 oe", pin_oe_o, 16'h00FF);
  endtask

  task automatic t_port1;
    logic [7:0] d;
    bus_wr(2'd3, 8'hDB);
    bus_rd(2'd3, d);
    check("R9 ctrl readback", {8'h0, d}, 16'h00DB);
    bus_wr(2'd2, 8'h0F);
    check("R2 port1 dir", pin_oe_o, 16'h0FFF);
    bus_wr(2'd3, 8'h04);
    bus_wr(2'd2, 8'h5A);
    check("R4 port1 drive", pin_o, 16'h0AA5);
    @(negedge clk_i); pin_i[15:8] = 8'h90;
    repeat (2) @(negedge clk_i);
    bus_rd(2'd2, d);
    check("R5 port1 merge", {8'h0, d}, 16'h009A);
    bus_rd(2'd1, d);
    check("R2 port0 ctrl", {8'h0, d}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_direction();
    t_merge_sync();
    t_hidden_latch();
    t_isolation();
    t_port1();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule